// File: doc/BRIEF.md
# Direct-Mapped Line Cache

This block is a direct-mapped cache between a word-addressed processor port and a slower backing memory. It holds 512 words as 64 lines of 8 words. Each processor address is split into a word offset, a line index and a tag. The line index picks one stored tag and valid flag. A valid line whose stored tag equals the request's tag is a hit. Any other access is a miss, and the block then reloads the whole 8-word line from memory before it answers.

A parameter selects the write policy. With write-through, every processor write is also sent to memory as a single-word write before the response. With write-back, a write touches only the cache and marks the line dirty. A dirty line is copied back to memory in full before another line is loaded into its slot. A write miss first loads the line and then merges the write word into it. Two counters record hits and misses, so software or a bench can compute the hit ratio.

The processor raises `cpu_req` with address, direction and data, and holds them until the one-cycle `cpu_done` pulse. Memory transfers are single words: `mem_req` is held with a stable address and direction until `mem_ack`, and read data is taken in the `mem_ack` cycle.

Top module: `dm_line_cache`

## Requirements
- R1: Address bits [2:0] select the word within a line, bits [8:3] select one of 64 lines, and the bits above form the tag, for a capacity of 512 words.
- R2: After reset, `cpu_done` and `mem_req` are low, both counters read zero, and every line is invalid, so the first access to any line is a miss.
- R3: A read hit raises `cpu_done` one cycle after the request is taken, returns the cached word, adds one to `hit_count`, and makes no memory transfer.
- R4: A miss adds one to `miss_count` and reloads the addressed line with 8 memory reads at offsets 0 to 7 in ascending order. The response comes only after the last read.
- R5: With write-through selected, each processor write causes exactly one memory write of that word to that address, and `cpu_done` follows its handshake.
- R6: With write-back selected, a write hit completes one cycle after the request, updates only the cache and leaves the memory word unchanged.
- R7: With write-back selected, a miss on a dirty line first writes all 8 words of the old line to memory, at the old tag's addresses in ascending offset order, and only then starts the reload.
- R8: A write miss loads the line and then merges the write word, so later reads of that line return the written word and the line's other memory words.
- R9: Every read returns the most recent value the processor wrote to that address, or the memory's initial contents if it was never written.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `mem_we` hold their values into the next cycle.
- R11: `cpu_done` is a single-cycle pulse and is only raised for a request that was present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory transfer complete |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |
| hit_count | output | CNT_W | Hits since reset |
| miss_count | output | CNT_W | Misses since reset |

## Verification
A wrong stored tag or a stale valid flag shows up on the very next access to that line. The cycle count to `cpu_done` changes from one to a full reload, or the other way round, and the hit and miss counters drift from a reference tag model. A lost dirty flag or a wrong eviction address stays hidden until the line is replaced. At that point the backing memory holds stale words and the count of memory writes falls short. A broken merge shows on the first read-back of a write-missed line. Two copies of the block run side by side, one per write policy, on the same sweeps.

// File: rtl/dm_line_cache.sv
module dm_line_cache #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int OFF_W      = 3,
  parameter int IDX_W      = 6,
  parameter int CNT_W      = 16,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int LOC_W = IDX_W + OFF_W;
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << LOC_W;

  typedef enum logic [2:0] {S_IDLE, S_EVICT, S_FILL, S_CMPL, S_WT} st_t;
  st_t st;

  logic [ADDR_W-1:0] r_addr;
  logic              r_we;
  logic [DATA_W-1:0] r_wdata;
  logic [OFF_W-1:0]  cnt;
  logic [DATA_W-1:0] dat  [WORDS];
  logic [TAG_W-1:0]  tags [LINES];
  logic [LINES-1:0]  vld, drt;

  wire [IDX_W-1:0] c_idx = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [LOC_W-1:0] c_loc = cpu_addr[LOC_W-1:0];
  wire [IDX_W-1:0] r_idx = r_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] r_tag = r_addr[ADDR_W-1 -: TAG_W];
  wire [LOC_W-1:0] r_loc = r_addr[LOC_W-1:0];

  wire accept   = (st == S_IDLE) && cpu_req && !cpu_done;
  wire hit      = vld[c_idx] && (tags[c_idx] == c_tag);
  wire fill_ack = (st == S_FILL) && mem_ack;
  wire last     = (cnt == {OFF_W{1'b1}});

  assign mem_req   = (st == S_EVICT) || (st == S_FILL) || (st == S_WT);
  assign mem_we    = (st == S_EVICT) || (st == S_WT);
  assign mem_addr  = (st == S_EVICT) ? {tags[r_idx], r_idx, cnt} :
                     (st == S_FILL)  ? {r_tag, r_idx, cnt} : r_addr;
  assign mem_wdata = (st == S_EVICT) ? dat[{r_idx, cnt}] : r_wdata;

  always_ff @(posedge clk) begin
    if (accept && hit && cpu_we) dat[c_loc] <= cpu_wdata;
    else if (fill_ack)           dat[{r_idx, cnt}] <= mem_rdata;
    else if (st == S_CMPL && r_we) dat[r_loc] <= r_wdata;
    if (fill_ack && last) tags[r_idx] <= r_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      r_addr     <= '0;
      r_we       <= 1'b0;
      r_wdata    <= '0;
      cnt        <= '0;
      vld        <= '0;
      drt        <= '0;
      cpu_done   <= 1'b0;
      cpu_rdata  <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          r_addr  <= cpu_addr;
          r_we    <= cpu_we;
          r_wdata <= cpu_wdata;
          cnt     <= '0;
          if (hit) begin
            hit_count <= hit_count + 1'b1;
            if (!cpu_we) begin
              cpu_rdata <= dat[c_loc];
              cpu_done  <= 1'b1;
            end else if (WRITE_BACK) begin
              drt[c_idx] <= 1'b1;
              cpu_done   <= 1'b1;
            end else begin
              st <= S_WT;
            end
          end else begin
            miss_count <= miss_count + 1'b1;
            if (WRITE_BACK && vld[c_idx] && drt[c_idx]) st <= S_EVICT;
            else                                        st <= S_FILL;
          end
        end
        S_EVICT: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (last) st <= S_FILL;
        end
        S_FILL: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (last) begin
            vld[r_idx] <= 1'b1;
            drt[r_idx] <= 1'b0;
            st         <= S_CMPL;
          end
        end
        S_CMPL: begin
          if (!r_we) begin
            cpu_rdata <= dat[r_loc];
            cpu_done  <= 1'b1;
            st        <= S_IDLE;
          end else if (WRITE_BACK) begin
            drt[r_idx] <= 1'b1;
            cpu_done   <= 1'b1;
            st         <= S_IDLE;
          end else begin
            st <= S_WT;
          end
        end
        S_WT: if (mem_ack) begin
          cpu_done <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_done_had_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> $past(cpu_req));

  assert_burst_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && st != S_WT && mem_addr[OFF_W-1:0] != {OFF_W{1'b1}})
    |=> (mem_req && mem_addr[OFF_W-1:0] == $past(mem_addr[OFF_W-1:0]) + 1'b1));

  assert_wt_then_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!WRITE_BACK && mem_req && mem_we && mem_ack) |=> cpu_done);
endmodule

// File: tb/dm_line_cache_tb.sv
module dm_line_cache_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic        req_a = 1'b0, req_b = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;

  logic        done_a, done_b, mreq_a, mreq_b, mwe_a, mwe_b;
  logic        ack_a, ack_b;
  logic [15:0] rd_a, rd_b, mwd_a, mwd_b, mrd_a, mrd_b;
  logic [11:0] maddr_a, maddr_b;
  logic [15:0] hit_a, hit_b, miss_a, miss_b;

  dm_line_cache #(.WRITE_BACK(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(req_a), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_done(done_a), .cpu_rdata(rd_a), .mem_req(mreq_a),
    .mem_we(mwe_a), .mem_addr(maddr_a), .mem_wdata(mwd_a), .mem_ack(ack_a),
    .mem_rdata(mrd_a), .hit_count(hit_a), .miss_count(miss_a));

  dm_line_cache #(.WRITE_BACK(1'b0)) u_dut_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(req_b), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_done(done_b), .cpu_rdata(rd_b), .mem_req(mreq_b),
    .mem_we(mwe_b), .mem_addr(maddr_b), .mem_wdata(mwd_b), .mem_ack(ack_b),
    .mem_rdata(mrd_b), .hit_count(hit_b), .miss_count(miss_b));

  logic [15:0] mem_a [4096];
  logic [15:0] mem_b [4096];
  logic [15:0] gold  [4096];
  int          wcnt_a = 0, wcnt_b = 0, rcnt_a = 0, rcnt_b = 0;
  logic [2:0]  woff_a = '0, roff_a = '0, roff_b = '0;

  bit          mv [64];
  int          mt [64];
  bit          md [64];
  int          exp_hit = 0, exp_miss = 0, exp_evw = 0, exp_wtw = 0;

  function automatic logic [15:0] init_word(input int i);
    return 16'((i * 37 + 11) ^ (i >> 3));
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) ack_a <= 1'b0;
    else if (mreq_a && !ack_a) begin
      ack_a <= 1'b1;
      if (mwe_a) begin
        mem_a[maddr_a] = mwd_a;
        wcnt_a++;
        chk(maddr_a[2:0] == woff_a, "R7 writeback offset order", int'(maddr_a[2:0]), int'(woff_a));
        woff_a = woff_a + 3'd1;
      end else begin
        mrd_a <= mem_a[maddr_a];
        rcnt_a++;
        chk(maddr_a[2:0] == roff_a, "R4 refill offset order", int'(maddr_a[2:0]), int'(roff_a));
        roff_a = roff_a + 3'd1;
      end
    end else ack_a <= 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_n) ack_b <= 1'b0;
    else if (mreq_b && !ack_b) begin
      ack_b <= 1'b1;
      if (mwe_b) begin
        mem_b[maddr_b] = mwd_b;
        wcnt_b++;
      end else begin
        mrd_b <= mem_b[maddr_b];
        rcnt_b++;
        chk(maddr_b[2:0] == roff_b, "R4 refill offset order wt", int'(maddr_b[2:0]), int'(roff_b));
        roff_b = roff_b + 3'd1;
      end
    end else ack_b <= 1'b0;
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 1, 0);
    finish_run();
  end

  task automatic acc(input bit w, input int a, input logic [15:0] wd);
    int idx, tg, cyc, ca, cb;
    bit h, got_a, got_b;
    logic [15:0] ra, rb, old_a;
    idx = (a >> 3) & 63;
    tg  = a >> 9;
    h   = mv[idx] && (mt[idx] == tg);
    old_a = mem_a[a];
    if (h) exp_hit++;
    else begin
      exp_miss++;
      if (mv[idx] && md[idx]) exp_evw += 8;
      mv[idx] = 1'b1; mt[idx] = tg; md[idx] = 1'b0;
    end
    if (w) begin
      md[idx] = 1'b1;
      gold[a] = wd;
      exp_wtw++;
    end
    @(negedge clk);
    we = w; addr = 12'(a); wdata = wd;
    req_a = 1'b1; req_b = 1'b1;
    cyc = 0; got_a = 0; got_b = 0; ca = 0; cb = 0; ra = '0; rb = '0;
    while (!(got_a && got_b) && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (req_a && done_a) begin req_a = 1'b0; got_a = 1; ra = rd_a; ca = cyc; end
      if (req_b && done_b) begin req_b = 1'b0; got_b = 1; rb = rd_b; cb = cyc; end
    end
    chk(got_a && got_b, "R11 response arrives", int'(got_a) + int'(got_b), 2);
    req_a = 1'b0; req_b = 1'b0;
    if (!w) begin
      chk(ra == gold[a], "R9 read data write-back", int'(ra), int'(gold[a]));
      chk(rb == gold[a], "R9 read data write-through", int'(rb), int'(gold[a]));
      if (h) begin
        chk(ca == 1, "R3 hit latency write-back", ca, 1);
        chk(cb == 1, "R3 hit latency write-through", cb, 1);
      end else begin
        chk(ca > 16, "R4 miss waits for refill", ca, 17);
      end
    end else begin
      chk(mem_b[a] == wd, "R5 write-through memory updated", int'(mem_b[a]), int'(wd));
      chk(mem_a[a] == old_a, "R6 write-back memory untouched", int'(mem_a[a]), int'(old_a));
      if (h) chk(ca == 1, "R6 write-back hit latency", ca, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem_a[i] = init_word(i);
      mem_b[i] = init_word(i);
      gold[i]  = init_word(i);
    end
    for (int i = 0; i < 64; i++) begin mv[i] = 0; mt[i] = 0; md[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!done_a && !done_b, "R2 done low in reset", int'(done_a), 0);
    chk(!mreq_a && !mreq_b, "R2 mem_req low in reset", int'(mreq_a), 0);
    chk(hit_a == 0 && miss_a == 0, "R2 counters zero", int'(hit_a) + int'(miss_a), 0);
    rst_n = 1'b1;

    // R1: sweep one full cache image: one miss per line, seven hits each
    for (int a = 0; a < 512; a++) acc(1'b0, a, '0);
    chk(miss_a == 64, "R1 line misses", int'(miss_a), 64);
    chk(hit_a == 448, "R1 line hits", int'(hit_a), 448);
    chk(rcnt_a == 512, "R4 refill word count", rcnt_a, 512);

    // R6 / R5: write every cached word
    for (int a = 0; a < 512; a++) acc(1'b1, a, 16'(a) ^ 16'hA5A5);
    chk(wcnt_a == 0, "R6 no write-back traffic on hits", wcnt_a, 0);
    chk(wcnt_b == 512, "R5 one memory write per write", wcnt_b, 512);

    // R7: conflicting tag evicts every dirty line
    for (int a = 512; a < 1024; a++) acc(1'b0, a, '0);
    chk(wcnt_a == 512, "R7 evicted word count", wcnt_a, 512);
    for (int a = 0; a < 512; a++)
      chk(mem_a[a] == gold[a], "R7 evicted data in memory", int'(mem_a[a]), int'(gold[a]));

    // R8: write miss allocates and merges, then read the lines back
    for (int k = 0; k < 64; k++) acc(1'b1, 1024 + k * 8 + (k % 8), 16'(k * 101 + 7));
    for (int a = 1024; a < 1536; a++) acc(1'b0, a, '0);

    // R4 / R7: alternate two tags per line so every access misses
    for (int k = 0; k < 64; k++) begin
      acc(1'b0, 1536 + k * 8, '0);
      acc(1'b1, 3584 + k * 8 + 1, 16'(k + 3));
      acc(1'b0, 1536 + k * 8 + 2, '0);
    end

    chk(hit_a == 16'(exp_hit), "R3 hit counter write-back", int'(hit_a), exp_hit);
    chk(miss_a == 16'(exp_miss), "R4 miss counter write-back", int'(miss_a), exp_miss);
    chk(hit_b == 16'(exp_hit), "R3 hit counter write-through", int'(hit_b), exp_hit);
    chk(miss_b == 16'(exp_miss), "R4 miss counter write-through", int'(miss_b), exp_miss);
    chk(wcnt_a == exp_evw, "R7 total eviction writes", wcnt_a, exp_evw);
    chk(wcnt_b == exp_wtw, "R5 total write-through writes", wcnt_b, exp_wtw);
    chk(rcnt_a == 8 * exp_miss, "R4 total refill reads", rcnt_a, 8 * exp_miss);
    finish_run();
  end
endmodule